// File: doc/BRIEF.md
# Dual-Compare 8-bit Timer/Counter

This block is a small timer peripheral reached through a flat register bus. An 8-bit counter steps once per count event. The count event is either a one-cycle pulse from an outside prescaler, or a chosen edge of an external count pin. The pin is brought into the clock domain through a flop synchronizer. The counter can be read at any time and loaded at any time.

Two compare channels hold an 8-bit value each. On every count event each channel checks its value against the counter value as it was before the step. A hit latches a flag and toggles that channel's waveform output. When the counter wraps, an overflow flag is latched.

Each flag is cleared either by writing a one to its bit or by an acknowledge pulse for that source. A flag is forwarded as an interrupt request only when its mask bit is set and the global enable input is high. Loading the counter suppresses compare hits on the first count event that follows the load. This keeps a freshly loaded value from producing a hit that the count did not reach by itself.

Top module: `tmr8_dual_cmp`

## Requirements
- R1: After reset, every register reads 0, and irq_o and wave_o are 0. The register addresses are: 0 counter, 1 compare A, 2 compare B, 3 mask, 4 flags, 5 control. Addresses 6 and 7 read 0.
- R2: The counter is loaded by a write to address 0 and read back from it. Control bits [1:0] select the count source: 0 means stopped, 1 means tick_i, 2 means rising pin edges and 3 means falling pin edges. With source 1, each cycle with tick_i high adds one. With source 0, the counter holds.
- R3: On a count event, if the counter value before the step equals compare A, flag bit 1 sets. If it equals compare B, flag bit 2 sets.
- R4: A counter write blocks compare hits on the next count event, both the flag and the toggle. Hits resume on the count event after that.
- R5: A count event with the counter at 0xFF gives 0x00 and sets flag bit 0. This happens even on a blocked count event.
- R6: Each unblocked compare hit toggles that channel's waveform output: wave_o[0] for A and wave_o[1] for B.
- R7: Mask bits are 0 for overflow, 1 for A and 2 for B. Mask bits 7..3 always read 0.
- R8: irq_o[k] is high exactly when flag k, mask k and gie_i are all 1.
- R9: Writing to address 4 clears each flag whose data bit is 1. Data bits of 0 leave their flags unchanged.
- R10: A one-cycle pulse on ack_i[k] clears flag k.
- R11: In pin modes, the counter advances once per selected edge of ext_pin_i, after a two-flop synchronizer. The pin is counted whatever drives it.
- R12: When a counter write and a count event fall in the same cycle, the written value is kept and there is no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| tick_i | input | 1 | Prescaled count pulse |
| ext_pin_i | input | 1 | External count pin |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 3 | Per-source acknowledge: bit 0 overflow, bit 1 A, bit 2 B |
| irq_o | output | 3 | Per-source interrupt request |
| wave_o | output | 2 | Toggle outputs: bit 0 A, bit 1 B |

## Verification
The compare path is driven through a table of load, compare and tick-count settings, and each row separates a distinct case:
- an ordinary hit mid-run;
- a hit sitting exactly on the loaded value, which must be blocked;
- a single blocked tick;
- hits on both sides of the 0xFF wrap in one run.

Flag and toggle results show whether the block comes from the load or from a wrong compare instant. Directed cases then set interrupt mask and enable combinations against latched flags, and partial write-one-clear against acknowledge pulses. They also cover a load colliding with a tick, and alternating pin levels under rising and falling selection, so that a wrong edge polarity shows up as a wrong count.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    CS_STOP     = 2'd0,
    CS_TICK     = 2'd1,
    CS_PIN_RISE = 2'd2,
    CS_PIN_FALL = 2'd3
  } clk_sel_e;

  localparam int unsigned FLG_OVF = 0;
endpackage

// File: rtl/tmr8_pin_edge.sv
module tmr8_pin_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
  assign fall_o = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         blk_o,
  output logic         adv_o
);
  logic [W-1:0] cnt_q;
  logic         blk_q;

  // load wins over a same-cycle count event; load arms the one-event block
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else if (wr_i) begin
      cnt_q <= wdata_i;
      blk_q <= 1'b1;
    end else if (en_i) begin
      cnt_q <= cnt_q + 1'b1;
      blk_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign blk_o = blk_q;
  assign adv_o = en_i & ~wr_i;
endmodule

// File: rtl/tmr8_cmp_chan.sv
module tmr8_cmp_chan #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cnt_i,
  input  logic         ok_i,
  output logic [W-1:0] cmp_o,
  output logic         hit_o,
  output logic         wave_o
);
  logic [W-1:0] cmp_q;
  logic         wave_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cmp_q <= '0;
    else if (wr_i) cmp_q <= wdata_i;
  end

  assign hit_o = ok_i & (cnt_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    wave_q <= 1'b0;
    else if (hit_o) wave_q <= ~wave_q;
  end

  assign cmp_o  = cmp_q;
  assign wave_o = wave_q;
endmodule

// File: rtl/tmr8_dual_cmp.sv
module tmr8_dual_cmp
  import tmr8_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned NUM_CMP     = 2,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [CNT_W-1:0]    wdata_i,
  output logic [CNT_W-1:0]    rdata_o,
  input  logic                tick_i,
  input  logic                ext_pin_i,
  input  logic                gie_i,
  input  logic [NUM_CMP:0]    ack_i,
  output logic [NUM_CMP:0]    irq_o,
  output logic [NUM_CMP-1:0]  wave_o
);
  localparam int unsigned NUM_SRC = NUM_CMP + 1;
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(0);
  localparam int unsigned       A_CMP0 = 1;
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(NUM_CMP + 1);
  localparam logic [ADDR_W-1:0] A_FLG = ADDR_W'(NUM_CMP + 2);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(NUM_CMP + 3);

  logic               pin_rise, pin_fall;
  logic               cnt_en, cnt_wr, cnt_adv, cnt_blk, cmp_ok;
  logic [CNT_W-1:0]   cnt_val;
  logic [CNT_W-1:0]   cmp_val [NUM_CMP];
  logic [NUM_CMP-1:0] cmp_hit;
  logic [NUM_SRC-1:0] msk_q, flg_q, flg_set, flg_w1c;
  clk_sel_e           cs_q;

  tmr8_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_pin_i),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  always_comb begin
    unique case (cs_q)
      CS_TICK:     cnt_en = tick_i;
      CS_PIN_RISE: cnt_en = pin_rise;
      CS_PIN_FALL: cnt_en = pin_fall;
      default:     cnt_en = 1'b0;
    endcase
  end

  assign cnt_wr = wr_en_i && (addr_i == A_CNT);

  tmr8_counter #(.W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cnt_wr),
    .wdata_i (wdata_i),
    .en_i    (cnt_en),
    .cnt_o   (cnt_val),
    .blk_o   (cnt_blk),
    .adv_o   (cnt_adv)
  );

  assign cmp_ok = cnt_adv & ~cnt_blk;

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    localparam logic [ADDR_W-1:0] A_K = ADDR_W'(A_CMP0 + k);
    tmr8_cmp_chan #(.W(CNT_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_en_i && (addr_i == A_K)),
      .wdata_i (wdata_i),
      .cnt_i   (cnt_val),
      .ok_i    (cmp_ok),
      .cmp_o   (cmp_val[k]),
      .hit_o   (cmp_hit[k]),
      .wave_o  (wave_o[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msk_q <= '0;
      cs_q  <= CS_STOP;
    end else if (wr_en_i) begin
      if (addr_i == A_MSK) msk_q <= wdata_i[NUM_SRC-1:0];
      if (addr_i == A_CTL) cs_q  <= clk_sel_e'(wdata_i[1:0]);
    end
  end

  // overflow is not subject to the load block
  assign flg_set = {cmp_hit, cnt_adv && (cnt_val == '1)};
  assign flg_w1c = (wr_en_i && addr_i == A_FLG) ? wdata_i[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= (flg_q & ~flg_w1c & ~ack_i) | flg_set;
  end

  assign irq_o = flg_q & msk_q & {NUM_SRC{gie_i}};

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CNT) rdata_o = cnt_val;
    for (int i = 0; i < NUM_CMP; i++)
      if (addr_i == ADDR_W'(A_CMP0 + i)) rdata_o = cmp_val[i];
    if (addr_i == A_MSK) rdata_o[NUM_SRC-1:0] = msk_q;
    if (addr_i == A_FLG) rdata_o[NUM_SRC-1:0] = flg_q;
    if (addr_i == A_CTL) rdata_o[1:0] = cs_q;
  end
endmodule

// File: rtl/tmr8_dual_cmp_chk.sv
module tmr8_dual_cmp_chk #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned NUM_CMP = 2,
  parameter int unsigned ADDR_W  = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               wr_en_i,
  input logic [CNT_W-1:0]   wdata_i,
  input logic [CNT_W-1:0]   rdata_o,
  input logic               gie_i,
  input logic [NUM_CMP:0]   irq_o,
  input logic [NUM_CMP-1:0] wave_o,
  input logic               adv_i,
  input logic               blk_i,
  input logic [CNT_W-1:0]   cnt_i
);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(NUM_CMP + 1);

  // R8
  irq_needs_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> irq_o == '0);

  // R7
  msk_rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == A_MSK |-> rdata_o[CNT_W-1:NUM_CMP+1] == '0);

  // R12
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_CNT) |=> cnt_i == $past(wdata_i));

  // R5
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && cnt_i == '1) |=> cnt_i == '0);

  // R2
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1));

  // R4
  blocked_no_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && blk_i) |=> $stable(wave_o));

  // R6
  idle_no_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(wave_o));
endmodule

bind tmr8_dual_cmp tmr8_dual_cmp_chk #(
  .CNT_W(CNT_W), .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_en_i (wr_en_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .gie_i   (gie_i),
  .irq_o   (irq_o),
  .wave_o  (wave_o),
  .adv_i   (cnt_adv),
  .blk_i   (cnt_blk),
  .cnt_i   (cnt_val)
);

// File: tb/tmr8_dual_cmp_tb.sv
`timescale 1ns/1ps
module tmr8_dual_cmp_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tick = 1'b0;
  logic       pin = 1'b0;
  logic       gie = 1'b0;
  logic [2:0] ack = '0;
  logic [2:0] irq;
  logic [1:0] wave;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  tmr8_dual_cmp u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .ext_pin_i(pin),
    .gie_i(gie), .ack_i(ack), .irq_o(irq), .wave_o(wave)
  );

  // {start, ticks, cmp_a, cmp_b, exp_cnt, exp_flags}
  localparam logic [47:0] VEC [6] = '{
    {8'h10, 8'd4, 8'h12, 8'h20, 8'h14, 8'h02},
    {8'h10, 8'd4, 8'h10, 8'h13, 8'h14, 8'h04},
    {8'hFE, 8'd3, 8'h00, 8'hFF, 8'h01, 8'h07},
    {8'h40, 8'd1, 8'h40, 8'h40, 8'h41, 8'h00},
    {8'h80, 8'd5, 8'h84, 8'h81, 8'h85, 8'h06},
    {8'hFF, 8'd2, 8'hFF, 8'h00, 8'h01, 8'h05}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pin_set(input logic v);
    @(negedge clk); pin = v;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [1:0] exp_wave;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reg", v, 0);
    end
    chk("R1 irq", irq, 0);
    chk("R1 wave", wave, 0);

    // R7 reserved mask bits
    wr(3'd3, 8'hFF);
    rd(3'd3, v); chk("R7 mask", v, 8'h07);
    wr(3'd3, 8'h00);

    // R2 stopped vs tick source
    wr(3'd0, 8'h05);
    ticks(2);
    rd(3'd0, v); chk("R2 stopped", v, 8'h05);
    wr(3'd5, 8'h01);
    rd(3'd5, v); chk("R2 ctrl", v, 8'h01);
    ticks(3);
    rd(3'd0, v); chk("R2 count", v, 8'h08);

    // R3 R4 R5 R6 table
    exp_wave = 2'b00;
    for (int e = 0; e < 6; e++) begin
      logic [47:0] t;
      t = VEC[e];
      wr(3'd0, t[47:40]);
      wr(3'd1, t[31:24]);
      wr(3'd2, t[23:16]);
      wr(3'd4, 8'h07);
      ticks(int'(t[39:32]));
      rd(3'd0, v); chk("R2 table cnt", v, t[15:8]);
      rd(3'd4, v); chk("R3 R4 R5 table flags", v, t[7:0]);
      exp_wave = exp_wave ^ t[2:1];
      chk("R6 table wave", wave, exp_wave);
    end

    // R8 gating; flags from last setup
    wr(3'd0, 8'hFE); wr(3'd1, 8'h00); wr(3'd2, 8'hFF); wr(3'd4, 8'h07);
    ticks(3);
    rd(3'd4, v); chk("R5 flags set", v, 8'h07);
    gie = 1'b1; #1;
    chk("R8 mask0", irq, 3'b000);
    wr(3'd3, 8'h07);
    gie = 1'b0; #1;
    chk("R8 gie0", irq, 3'b000);
    gie = 1'b1; #1;
    chk("R8 all", irq, 3'b111);
    wr(3'd3, 8'h02); #1;
    chk("R8 maskA", irq, 3'b010);

    // R9 write-one-clear
    wr(3'd4, 8'h02);
    rd(3'd4, v); chk("R9 partial", v, 8'h05);
    wr(3'd4, 8'h00);
    rd(3'd4, v); chk("R9 zero write", v, 8'h05);

    // R10 acknowledge
    @(negedge clk); ack = 3'b100;
    @(negedge clk); ack = 3'b000;
    rd(3'd4, v); chk("R10 ack", v, 8'h01);
    wr(3'd3, 8'h07); #1;
    chk("R10 irq", irq, 3'b001);

    // R12 load with tick in the same cycle
    @(negedge clk);
    addr = 3'd0; wdata = 8'h30; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    rd(3'd0, v); chk("R12 load kept", v, 8'h30);
    ticks(1);
    rd(3'd0, v); chk("R12 then step", v, 8'h31);

    // R11 pin edges
    wr(3'd5, 8'h02);
    wr(3'd0, 8'h00);
    pin_set(1'b1);
    rd(3'd0, v); chk("R11 rise", v, 8'h01);
    pin_set(1'b0);
    rd(3'd0, v); chk("R11 fall ignored", v, 8'h01);
    pin_set(1'b1);
    rd(3'd0, v); chk("R11 rise2", v, 8'h02);
    wr(3'd5, 8'h03);
    pin_set(1'b0);
    rd(3'd0, v); chk("R11 fall mode", v, 8'h03);
    pin_set(1'b1);
    rd(3'd0, v); chk("R11 rise ignored", v, 8'h03);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule